// File: doc/BRIEF.md
# Linked Command List Walker

The walker runs a chain of command blocks kept in memory, one block after another, through a simple 16-bit word memory port with a request/ready handshake. Each block is a small record: a status word at byte offset 0, a command word at offset 2 and a 32-bit link to the next block at offset 4, stored as two 16-bit words with the low half first. The walker marks a block as busy, fetches its command word, hands the 3-bit operation code to an external executor and waits for that executor to finish. It then marks the block complete and follows the link.

Three flag bits in the command word control the walk. Bit 15 makes the current block the last one. Bit 14 parks the command unit in a suspended state once the block is done. Bit 13 raises the command-complete flag and asks for an interrupt. When bit 13 is clear, the complete flag is cleared. A link of all zeros or all ones ends the walk. The walker shows its command-unit state (0 idle, 1 suspended, 2 active) so that the surrounding control logic can report it. A start request carries the address of the first block. Software-visible acknowledgement of the flags belongs to that surrounding logic.

Top module: `cmd_chain_walker`

## Requirements
- R1: While reset is asserted, busy_o, mem_req_o, exec_valid_o, irq_o, susp_o and cx_o are 0, and cu_state_o is 0 (idle).
- R2: A start accepted with a non-null head address makes busy_o and cu_state_o = 2 (active) visible one cycle later. The first memory access writes 0x4000 to the head block's offset 0.
- R3: After the busy mark, the walker reads the command word at offset 2. It then holds exec_valid_o with exec_op_o = command bits 2:0 and exec_blk_o = block address until exec_done_i is sampled high.
- R4: After the executor handshake, the walker writes 0xA000 to the block's offset 0.
- R5: When neither bit 15 nor bit 14 of the command is set, the walker reads offset 4 (low half), then offset 6 (high half). It continues with the busy mark of the block at {high, low}.
- R6: A link of 0x00000000 or 0xFFFFFFFF ends the walk: busy_o falls and cu_state_o returns to 0 one cycle after the high-half read. A start with a null head makes no memory access and sets cu_state_o to 0.
- R7: Command bit 15 ends the walk right after the completion write, with no link read, and leaves cu_state_o at 0.
- R8: Command bit 14 ends the walk after the completion write with no link read. It sets cu_state_o to 1 (suspended) and pulses susp_o for one cycle, visible in the cycle after that write's handshake. Bit 14 takes priority over bit 15.
- R9: In the cycle after each completion write, cx_o takes the value of command bit 13. irq_o is a one-cycle pulse in that cycle exactly when bit 13 is set.
- R10: Any number of wait cycles on mem_ready_i and exec_done_i is tolerated. While a request waits, mem_req_o, mem_we_o, mem_addr_o and mem_wdata_o hold steady.
- R11: A start request while busy_o is high has no effect on the walk or on memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start a walk at head_ptr_i (ignored while busy) |
| head_ptr_i | input | ADDR_W | Byte address of the first block |
| busy_o | output | 1 | Walk in progress |
| cu_state_o | output | 2 | Command unit state: 0 idle, 1 suspended, 2 active |
| mem_req_o | output | 1 | Memory request, held until mem_ready_i |
| mem_we_o | output | 1 | 1 write, 0 read |
| mem_addr_o | output | ADDR_W | Byte address of the 16-bit word |
| mem_wdata_o | output | 16 | Write data |
| mem_ready_i | input | 1 | Completes the request in this cycle |
| mem_rdata_i | input | 16 | Read data, valid with mem_ready_i |
| exec_valid_o | output | 1 | Operation handed to the executor |
| exec_op_o | output | 3 | Operation code (command bits 2:0) |
| exec_blk_o | output | ADDR_W | Address of the block being executed |
| exec_done_i | input | 1 | Executor finished the operation |
| cx_o | output | 1 | Command-complete flag from the last finished block |
| irq_o | output | 1 | One-cycle interrupt pulse |
| susp_o | output | 1 | One-cycle pulse when the unit suspends |

## Verification
The bench uses the default ADDR_W of 32, so link pointers match the two-word layout exactly. This lets blocks sit near the very top of the address space, at 0xFFFFFFF0, and lets a chain end on either null encoding. Memory and executor wait cycles are drawn pseudo-randomly from 0 to 3 per transaction. The test set covers chains that end on a zero link, on an all-ones link, on bit 15, on bit 14, and on both bits 14 and 15 together. It also covers a resume from the suspended state, starts with null heads, and a start issued in the middle of a walk.

// File: rtl/clw_pkg.sv
package clw_pkg;
  localparam int WORD_W = 16;
  localparam int OP_W   = 3;

  localparam int BIT_EOL  = 15;
  localparam int BIT_SUSP = 14;
  localparam int BIT_INT  = 13;

  localparam int OFS_CMD     = 2;
  localparam int OFS_LINK_LO = 4;
  localparam int OFS_LINK_HI = 6;

  localparam logic [WORD_W-1:0] STAT_BUSY = 16'h4000;
  localparam logic [WORD_W-1:0] STAT_DONE = 16'hA000;

  typedef enum logic [2:0] {
    ST_IDLE, ST_MARK, ST_FETCH, ST_EXEC, ST_CLOSE, ST_LINK_LO, ST_LINK_HI
  } walk_st_e;

  typedef enum logic [1:0] {
    CU_IDLE = 2'd0, CU_SUSP = 2'd1, CU_ACTIVE = 2'd2
  } cu_st_e;
endpackage

// File: rtl/clw_ptr.sv
module clw_ptr
  import clw_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              head_we,
  input  logic [ADDR_W-1:0] head,
  input  logic              lo_we,
  input  logic              next_we,
  input  logic [WORD_W-1:0] rdata,
  output logic [ADDR_W-1:0] blk,
  output logic              head_null,
  output logic              next_null
);
  localparam int LINK_W = 2 * WORD_W;

  logic [WORD_W-1:0] lo_q, lo_d;
  logic [ADDR_W-1:0] blk_q, blk_d;
  logic [LINK_W-1:0] link;

  assign link = {rdata, lo_q};

  always_comb begin
    lo_d  = lo_we ? rdata : lo_q;
    blk_d = blk_q;
    if (head_we)      blk_d = head;
    else if (next_we) blk_d = ADDR_W'(link);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q  <= '0;
      blk_q <= '0;
    end else begin
      lo_q  <= lo_d;
      blk_q <= blk_d;
    end
  end

  assign blk       = blk_q;
  assign head_null = (head == '0) || (head == '1);
  assign next_null = (link == '0) || (link == '1);
endmodule

// File: rtl/clw_seq.sv
module clw_seq
  import clw_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              head_null,
  input  logic              next_null,
  input  logic [ADDR_W-1:0] blk,
  input  logic              mem_ready,
  input  logic [WORD_W-1:0] mem_rdata,
  input  logic              exec_done,
  output logic              head_we,
  output logic              lo_we,
  output logic              next_we,
  output logic              busy,
  output logic [1:0]        cu_state,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  output logic              exec_valid,
  output logic [OP_W-1:0]   exec_op,
  output logic              cx,
  output logic              irq,
  output logic              susp
);
  localparam logic [ADDR_W-1:0] A_CMD = ADDR_W'(OFS_CMD);
  localparam logic [ADDR_W-1:0] A_LO  = ADDR_W'(OFS_LINK_LO);
  localparam logic [ADDR_W-1:0] A_HI  = ADDR_W'(OFS_LINK_HI);

  walk_st_e        st_q, st_d;
  cu_st_e          cu_q, cu_d;
  logic [OP_W-1:0] op_q, op_d;
  logic            eol_q, eol_d, sus_q, sus_d, int_q, int_d;
  logic            cx_q, cx_d, irq_q, irq_d, susp_q, susp_d;
  logic            rdata_unused;

  assign rdata_unused = ^mem_rdata[BIT_INT-1:OP_W];

  always_comb begin
    st_d = st_q;  cu_d = cu_q;  op_d = op_q;
    eol_d = eol_q; sus_d = sus_q; int_d = int_q;
    cx_d = cx_q;  irq_d = 1'b0; susp_d = 1'b0;
    head_we = 1'b0; lo_we = 1'b0; next_we = 1'b0;
    mem_req = 1'b0; mem_we = 1'b0; mem_addr = blk; mem_wdata = STAT_BUSY;
    exec_valid = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (start) begin
          if (head_null) cu_d = CU_IDLE;
          else begin
            head_we = 1'b1;
            cu_d    = CU_ACTIVE;
            st_d    = ST_MARK;
          end
        end
      end
      ST_MARK: begin
        mem_req = 1'b1;
        mem_we  = 1'b1;
        if (mem_ready) st_d = ST_FETCH;
      end
      ST_FETCH: begin
        mem_req  = 1'b1;
        mem_addr = blk + A_CMD;
        if (mem_ready) begin
          op_d  = mem_rdata[OP_W-1:0];
          eol_d = mem_rdata[BIT_EOL];
          sus_d = mem_rdata[BIT_SUSP];
          int_d = mem_rdata[BIT_INT];
          st_d  = ST_EXEC;
        end
      end
      ST_EXEC: begin
        exec_valid = 1'b1;
        if (exec_done) st_d = ST_CLOSE;
      end
      ST_CLOSE: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_wdata = STAT_DONE;
        if (mem_ready) begin
          cx_d  = int_q;
          irq_d = int_q;
          if (sus_q) begin
            cu_d   = CU_SUSP;
            susp_d = 1'b1;
            st_d   = ST_IDLE;
          end else if (eol_q) begin
            cu_d = CU_IDLE;
            st_d = ST_IDLE;
          end else begin
            st_d = ST_LINK_LO;
          end
        end
      end
      ST_LINK_LO: begin
        mem_req  = 1'b1;
        mem_addr = blk + A_LO;
        if (mem_ready) begin
          lo_we = 1'b1;
          st_d  = ST_LINK_HI;
        end
      end
      ST_LINK_HI: begin
        mem_req  = 1'b1;
        mem_addr = blk + A_HI;
        if (mem_ready) begin
          if (next_null) begin
            cu_d = CU_IDLE;
            st_d = ST_IDLE;
          end else begin
            next_we = 1'b1;
            st_d    = ST_MARK;
          end
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE;  cu_q <= CU_IDLE;  op_q <= '0;
      eol_q <= 1'b0; sus_q <= 1'b0; int_q <= 1'b0;
      cx_q <= 1'b0;  irq_q <= 1'b0; susp_q <= 1'b0;
    end else begin
      st_q <= st_d;  cu_q <= cu_d;  op_q <= op_d;
      eol_q <= eol_d; sus_q <= sus_d; int_q <= int_d;
      cx_q <= cx_d;  irq_q <= irq_d; susp_q <= susp_d;
    end
  end

  assign busy     = (st_q != ST_IDLE);
  assign cu_state = cu_q;
  assign exec_op  = op_q;
  assign cx       = cx_q;
  assign irq      = irq_q;
  assign susp     = susp_q;
endmodule

// File: rtl/cmd_chain_walker.sv
module cmd_chain_walker
  import clw_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] head_ptr_i,
  output logic              busy_o,
  output logic [1:0]        cu_state_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [15:0]       mem_wdata_o,
  input  logic              mem_ready_i,
  input  logic [15:0]       mem_rdata_i,
  output logic              exec_valid_o,
  output logic [2:0]        exec_op_o,
  output logic [ADDR_W-1:0] exec_blk_o,
  input  logic              exec_done_i,
  output logic              cx_o,
  output logic              irq_o,
  output logic              susp_o
);
  logic              head_we, lo_we, next_we, head_null, next_null;
  logic [ADDR_W-1:0] blk;

  clw_ptr #(.ADDR_W(ADDR_W)) u_ptr (
    .clk       (clk),
    .rst_n     (rst_n),
    .head_we   (head_we),
    .head      (head_ptr_i),
    .lo_we     (lo_we),
    .next_we   (next_we),
    .rdata     (mem_rdata_i),
    .blk       (blk),
    .head_null (head_null),
    .next_null (next_null)
  );

  clw_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start_i),
    .head_null  (head_null),
    .next_null  (next_null),
    .blk        (blk),
    .mem_ready  (mem_ready_i),
    .mem_rdata  (mem_rdata_i),
    .exec_done  (exec_done_i),
    .head_we    (head_we),
    .lo_we      (lo_we),
    .next_we    (next_we),
    .busy       (busy_o),
    .cu_state   (cu_state_o),
    .mem_req    (mem_req_o),
    .mem_we     (mem_we_o),
    .mem_addr   (mem_addr_o),
    .mem_wdata  (mem_wdata_o),
    .exec_valid (exec_valid_o),
    .exec_op    (exec_op_o),
    .cx         (cx_o),
    .irq        (irq_o),
    .susp       (susp_o)
  );

  assign exec_blk_o = blk;
endmodule

// File: rtl/clw_checker.sv
module clw_checker #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] head_ptr_i,
  input logic              busy_o,
  input logic [1:0]        cu_state_o,
  input logic              mem_req_o,
  input logic              mem_we_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic [15:0]       mem_wdata_o,
  input logic              mem_ready_i,
  input logic              exec_valid_o,
  input logic [2:0]        exec_op_o,
  input logic [ADDR_W-1:0] exec_blk_o,
  input logic              exec_done_i,
  input logic              cx_o,
  input logic              irq_o,
  input logic              susp_o
);
  p_first_mark_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> mem_req_o && mem_we_o && mem_wdata_o == 16'h4000
                      && mem_addr_o == $past(head_ptr_i));

  p_exec_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    exec_valid_o && !exec_done_i |=> exec_valid_o && $stable(exec_op_o)
                                      && $stable(exec_blk_o));

  p_susp_state_r8: assert property (@(posedge clk) disable iff (!rst_n)
    susp_o |-> cu_state_o == 2'd1 && !busy_o);

  p_irq_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |=> !irq_o);

  p_irq_source_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> cx_o && $past(mem_req_o && mem_ready_i && mem_we_o
                            && mem_wdata_o == 16'hA000));

  p_req_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_o && !mem_ready_i |=> mem_req_o && $stable(mem_we_o)
                                  && $stable(mem_addr_o) && $stable(mem_wdata_o));

  p_busy_active_r11: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> cu_state_o == 2'd2);
endmodule

bind cmd_chain_walker clw_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .head_ptr_i   (head_ptr_i),
  .busy_o       (busy_o),
  .cu_state_o   (cu_state_o),
  .mem_req_o    (mem_req_o),
  .mem_we_o     (mem_we_o),
  .mem_addr_o   (mem_addr_o),
  .mem_wdata_o  (mem_wdata_o),
  .mem_ready_i  (mem_ready_i),
  .exec_valid_o (exec_valid_o),
  .exec_op_o    (exec_op_o),
  .exec_blk_o   (exec_blk_o),
  .exec_done_i  (exec_done_i),
  .cx_o         (cx_o),
  .irq_o        (irq_o),
  .susp_o       (susp_o)
);

// File: tb/cmd_chain_walker_test.sv
module cmd_chain_walker_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        start_i;
  logic [31:0] head_ptr_i;
  logic        busy_o;
  logic [1:0]  cu_state_o;
  logic        mem_req_o, mem_we_o;
  logic [31:0] mem_addr_o;
  logic [15:0] mem_wdata_o;
  logic        mem_ready_i;
  logic [15:0] mem_rdata_i;
  logic        exec_valid_o;
  logic [2:0]  exec_op_o;
  logic [31:0] exec_blk_o;
  logic        exec_done_i;
  logic        cx_o, irq_o, susp_o;

  always #2 clk = ~clk;

  cmd_chain_walker #(.ADDR_W(32)) uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .head_ptr_i(head_ptr_i),
    .busy_o(busy_o), .cu_state_o(cu_state_o),
    .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
    .mem_wdata_o(mem_wdata_o), .mem_ready_i(mem_ready_i), .mem_rdata_i(mem_rdata_i),
    .exec_valid_o(exec_valid_o), .exec_op_o(exec_op_o), .exec_blk_o(exec_blk_o),
    .exec_done_i(exec_done_i), .cx_o(cx_o), .irq_o(irq_o), .susp_o(susp_o)
  );

  typedef struct {
    int          kind;   // 0 write, 1 read, 2 exec
    logic [31:0] addr;
    logic [15:0] data;
    bit          close, irq, susp, cx, last;
    logic [1:0]  cu_end;
    int          rq;
  } ev_t;

  ev_t         evq[$];
  logic [15:0] mem [logic [31:0]];

  int checks = 0, fails = 0, cyc = 0, seed = 7;
  bit          mon_on = 1'b0;
  bit          exp_busy = 1'b0, exp_irq = 1'b0, exp_susp = 1'b0, exp_cx = 1'b0;
  logic [1:0]  exp_cu = 2'd0;
  int          mwait = 0, xwait = 0;
  logic        c_we;
  logic [31:0] c_addr;
  logic [15:0] c_wdata;
  logic [2:0]  c_op;
  logic [31:0] c_blk;

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", what, act, exp, cyc);
    end
  endtask

  function automatic int rnd();
    seed = seed * 1103515245 + 12345;
    return (seed >>> 16) & 3;
  endfunction

  function automatic logic [15:0] rd(input logic [31:0] a);
    if (mem.exists(a)) return mem[a];
    return 16'h0000;
  endfunction

  function automatic bit is_null(input logic [31:0] p);
    return (p == 32'h0) || (p == 32'hFFFF_FFFF);
  endfunction

  function automatic void push_ev(int kind, logic [31:0] a, logic [15:0] d, bit close,
                                  bit irq, bit susp, bit last, logic [1:0] cu_end, int rq);
    ev_t e;
    e.kind = kind; e.addr = a; e.data = d; e.close = close; e.irq = irq;
    e.susp = susp; e.cx = irq; e.last = last; e.cu_end = cu_end; e.rq = rq;
    evq.push_back(e);
  endfunction

  // Behavioural expectation of one walk, built from the requirements.
  function automatic void build(input logic [31:0] head);
    logic [31:0] p = head;
    for (int n = 0; n < 16; n++) begin
      logic [15:0] cmd = rd(p + 2);
      logic [31:0] nx;
      bit stop = cmd[14] | cmd[15];
      push_ev(0, p, 16'h4000, 0, 0, 0, 0, 2'd0, 2);           // R2
      push_ev(1, p + 2, 16'h0, 0, 0, 0, 0, 2'd0, 3);          // R3
      push_ev(2, p, {13'h0, cmd[2:0]}, 0, 0, 0, 0, 2'd0, 3);  // R3
      // R4 completion; R7 end on bit 15; R8 suspend on bit 14
      push_ev(0, p, 16'hA000, 1, cmd[13], cmd[14], stop,
              cmd[14] ? 2'd1 : 2'd0, cmd[14] ? 8 : (cmd[15] ? 7 : 4));
      if (stop) return;
      nx = {rd(p + 6), rd(p + 4)};
      push_ev(1, p + 4, 16'h0, 0, 0, 0, 0, 2'd0, 5);          // R5
      push_ev(1, p + 6, 16'h0, 0, 0, 0, is_null(nx), 2'd0, is_null(nx) ? 6 : 5);
      if (is_null(nx)) return;
      p = nx;
    end
  endfunction

  task automatic process_ev(input int kind, input logic [31:0] a, input logic [15:0] d);
    ev_t e;
    if (evq.size() == 0) begin
      checks++; fails++;
      $display("FAIL R11 unexpected transaction kind=%0d actual=%0h expected=none", kind, a);
      return;
    end
    e = evq.pop_front();
    chk(kind, e.kind, $sformatf("R%0d transaction kind", e.rq));
    chk(a, e.addr, $sformatf("R%0d address", e.rq));
    if (kind != 1) chk({16'h0, d}, {16'h0, e.data}, $sformatf("R%0d data", e.rq));
    if (e.close) begin
      exp_irq = e.irq; exp_susp = e.susp; exp_cx = e.cx;
    end
    if (e.last) begin
      exp_busy = 1'b0; exp_cu = e.cu_end;
    end
  endtask

  // Reference model and responders, evaluated 1 ns after each rising edge.
  always @(posedge clk) begin
    #1;
    if (mon_on) begin
      cyc++;
      exp_irq = 1'b0; exp_susp = 1'b0;
      if (start_i && !exp_busy) begin
        if (is_null(head_ptr_i)) exp_cu = 2'd0;
        else begin exp_busy = 1'b1; exp_cu = 2'd2; end
      end
      // R10: random wait cycles on the memory port
      if (mem_ready_i) begin
        if (c_we) mem[c_addr] = c_wdata;
        process_ev(c_we ? 0 : 1, c_addr, c_wdata);
        mem_ready_i = 1'b0;
        mwait = rnd();
      end else if (mem_req_o) begin
        if (mwait == 0) begin
          c_we = mem_we_o; c_addr = mem_addr_o; c_wdata = mem_wdata_o;
          if (!mem_we_o) mem_rdata_i = rd(mem_addr_o);
          mem_ready_i = 1'b1;
        end else mwait--;
      end
      if (exec_done_i) begin
        process_ev(2, c_blk, {13'h0, c_op});
        exec_done_i = 1'b0;
        xwait = rnd();
      end else if (exec_valid_o) begin
        if (xwait == 0) begin
          c_op = exec_op_o; c_blk = exec_blk_o; exec_done_i = 1'b1;
        end else xwait--;
      end
      chk(busy_o, exp_busy, "R6 busy_o");
      chk(cu_state_o, exp_cu, "R8 cu_state_o");
      chk(irq_o, exp_irq, "R9 irq_o");
      chk(susp_o, exp_susp, "R8 susp_o");
      chk(cx_o, exp_cx, "R9 cx_o");
      if (cyc > 150000) begin
        checks++; fails++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
      end
    end
  end

  task automatic set_blk(input logic [31:0] a, input logic [15:0] cmd, input logic [31:0] link);
    mem[a] = 16'h0; mem[a + 2] = cmd; mem[a + 4] = link[15:0]; mem[a + 6] = link[31:16];
  endtask

  task automatic kick(input logic [31:0] h);
    @(negedge clk);
    if (!exp_busy && !is_null(h)) build(h);
    head_ptr_i = h; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic wait_done();
    while (exp_busy || evq.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; start_i = 1'b0; head_ptr_i = '0;
    mem_ready_i = 1'b0; mem_rdata_i = '0; exec_done_i = 1'b0;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(busy_o, 0, "R1 busy_o");       chk(cu_state_o, 0, "R1 cu_state_o");
    chk(mem_req_o, 0, "R1 mem_req_o"); chk(exec_valid_o, 0, "R1 exec_valid_o");
    chk(irq_o, 0, "R1 irq_o");         chk(cx_o, 0, "R1 cx_o");
    chk(susp_o, 0, "R1 susp_o");
    rst_n = 1'b1; mon_on = 1'b1;

    // Three blocks ending on a zero link; interrupt on the middle one (R5, R6, R9)
    set_blk(32'h1000, 16'h0001, 32'h2000);
    set_blk(32'h2000, 16'h2002, 32'h0300);
    set_blk(32'h0300, 16'h0004, 32'h0000);
    kick(32'h1000); wait_done();

    // High address block, chain ends on an all-ones link (R6, R9)
    set_blk(32'hFFFF_FFF0, 16'h0007, 32'h0000_4000);
    set_blk(32'h4000, 16'h2000, 32'hFFFF_FFFF);
    kick(32'hFFFF_FFF0); wait_done();

    // R7: bit 15 ends the walk, link not followed
    set_blk(32'h5000, 16'h8003, 32'h6000);
    kick(32'h5000); wait_done();

    // R8: suspend with interrupt
    set_blk(32'h6000, 16'h6005, 32'h7000);
    kick(32'h6000); wait_done();

    // R6: null heads leave memory untouched and return the unit to idle
    kick(32'h0000_0000); wait_done();
    kick(32'h6000);      wait_done();
    kick(32'hFFFF_FFFF); wait_done();

    // Resume, then bits 14 and 15 together: suspend wins (R8)
    set_blk(32'h7000, 16'h0006, 32'h7100);
    set_blk(32'h7100, 16'hC001, 32'h1000);
    kick(32'h7000); wait_done();

    // R11: start during a walk is ignored
    set_blk(32'h1000, 16'h0001, 32'h2000);
    set_blk(32'h2000, 16'h2002, 32'h0300);
    set_blk(32'h0300, 16'h0004, 32'h0000);
    set_blk(32'h5000, 16'h0000, 32'h0000);
    kick(32'h1000);
    repeat (6) @(negedge clk);
    kick(32'h5000);
    wait_done();
    chk({16'h0, rd(32'h5000)}, 32'h0, "R11 ignored start left block untouched");
    chk(evq.size(), 0, "R11 no pending expected transactions");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule